// File: doc/BRIEF.md
# Programmable Bidirectional Parallel Port

An eight-line general-purpose port that sits behind an external address decoder on a processor bus. Each device line can be set as an input or an output, independently of the others, through a direction register. The processor reaches the port's registers with a request/acknowledge handshake. The device side has two control lines. One is a capture strobe from the device that freezes the input lines and raises an interrupt. The other is an output strobe that the port pulses after every new output byte.

Each device line is modelled as three separate vectors: the sampled level, the driven value and the drive enable. Line i drives `pin_out[i]` when `pin_oe[i]` is 1. Otherwise it is read from `pin_in[i]`. The register-select code picks one of up to eight register slots. Codes 3 to 7 are unpopulated.

Top module: `bidir_port`

## Requirements
- R1: While reset is asserted, `pin_oe`, `pin_out`, `bus_ack`, `bus_rdata`, `irq` and `out_strobe` are all 0, so every line starts as an input. Reset is asynchronous on assertion, and its release reaches the registers two clock edges later.
- R2: An access takes place on the first rising edge at which `dev_sel` and `bus_req` are both 1 while `bus_ack` is 0. From the next cycle, `bus_ack` stays 1 for as long as `dev_sel` and `bus_req` stay 1. Holding the request performs only one access.
- R3: Writing code 1 loads the direction register. `pin_oe` equals that register, where bit i = 1 makes line i an output. Reading code 1 returns it.
- R4: Writing code 0 loads the output register, which drives `pin_out`. `out_strobe` is 1 for exactly the one cycle after that write's access edge.
- R5: Reading code 0 returns, in each bit i, the output register bit when direction bit i is 1, and the data-in register bit when it is 0. With no capture pending, the data-in register follows `pin_in` with one cycle of delay.
- R6: A rising edge on `cap_strobe` loads `pin_in` into the data-in register and sets the capture flag (code 2, bit 0). The data-in register then holds that value, whatever `pin_in` does, until the flag is cleared.
- R7: A read of code 0 clears the capture flag. If a capture edge falls in the same cycle as that read, the flag stays set.
- R8: Code 2 bit 1 is a read/write interrupt enable, and code 2 reads as {6'b0, enable, flag}. `irq` is 1 exactly while both the flag and the enable are 1.
- R9: Reads of codes 3 to 7 return 0, and writes to them change no register. A write access returns 0 on `bus_rdata`. Read data is held until the next access.
- R10: A request made while `dev_sel` is 0 gets no acknowledge and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| dev_sel | input | 1 | Address-decoder hit that qualifies every access |
| reg_sel | input | 3 | Register select code |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data, valid while `bus_ack` is 1 |
| bus_req | input | 1 | Master request |
| bus_ack | output | 1 | Slave acknowledge |
| irq | output | 1 | Interrupt request |
| pin_in | input | 8 | Sampled level of the device lines |
| pin_out | output | 8 | Value driven on the device lines |
| pin_oe | output | 8 | Per-line drive enable (1 = output) |
| cap_strobe | input | 1 | Device capture strobe, rising-edge active |
| out_strobe | output | 1 | One-cycle pulse after each output-register write |

## Verification
The checker watches several properties on every cycle:
- the reset values;
- that an acknowledge only follows a qualified request;
- that the output strobe never lasts two cycles;
- that the drive enables and driven values change only after a write to their own code;
- that the interrupt rises only after a capture strobe or a control write.

Other behaviours can only be shown by the bench's scenarios, because they need particular values at the ports:
- the per-bit mix of output and input data on a code-0 read;
- the capture value being frozen while the pins move;
- the read that clears the flag;
- a capture colliding with that clearing read;
- unused codes and unselected requests leaving all state untouched.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned RSW = 3;

  typedef logic [RSW-1:0] rsel_t;

  localparam rsel_t RS_DATA = 3'd0;
  localparam rsel_t RS_DIR  = 3'd1;
  localparam rsel_t RS_CTRL = 3'd2;

  localparam int unsigned CTRL_FLAG_BIT = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
endpackage

// File: rtl/bpp_handshake.sv
module bpp_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic req,
  output logic ack,
  output logic access
);
  logic ack_d;

  always_comb begin
    ack_d  = sel & req;
    access = sel & req & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= ack_d;
  end
endmodule

// File: rtl/bpp_capture.sv
module bpp_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] pins,
  input  logic         clr,
  output logic [W-1:0] din,
  output logic         flag
);
  logic         strobe_q;
  logic         cap_edge;
  logic [W-1:0] din_d;
  logic         flag_d;
  logic         din_en;

  always_comb begin
    cap_edge = strobe & ~strobe_q;
    din_en   = cap_edge | ~flag;
    din_d    = pins;
    if (cap_edge)  flag_d = 1'b1;
    else if (clr)  flag_d = 1'b0;
    else           flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      flag     <= 1'b0;
      din      <= '0;
    end else begin
      strobe_q <= strobe;
      flag     <= flag_d;
      if (din_en) din <= din_d;
    end
  end
endmodule

// File: rtl/bpp_regs.sv
module bpp_regs
  import bpp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         access,
  input  logic         write,
  input  rsel_t        rs,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] din,
  input  logic         flag,
  output logic [W-1:0] dout,
  output logic [W-1:0] dir,
  output logic         ie,
  output logic [W-1:0] rdata,
  output logic         ostrobe,
  output logic         rd_data
);
  logic [W-1:0] mix;
  logic [W-1:0] ctrl_view;
  logic [W-1:0] rdata_d;
  logic         wr_data, wr_dir, wr_ctrl, rd_any;

  for (genvar i = 0; i < W; i++) begin : g_mix
    assign mix[i] = dir[i] ? dout[i] : din[i];
  end

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_FLAG_BIT] = flag;
    ctrl_view[CTRL_IE_BIT]   = ie;
    wr_data = access & write & (rs == RS_DATA);
    wr_dir  = access & write & (rs == RS_DIR);
    wr_ctrl = access & write & (rs == RS_CTRL);
    rd_any  = access & ~write;
    rd_data = rd_any & (rs == RS_DATA);
    rdata_d = '0;
    if (rd_any) begin
      unique case (rs)
        RS_DATA: rdata_d = mix;
        RS_DIR:  rdata_d = dir;
        RS_CTRL: rdata_d = ctrl_view;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dir     <= '0;
      ie      <= 1'b0;
      rdata   <= '0;
      ostrobe <= 1'b0;
    end else begin
      if (wr_data) dout  <= wdata;
      if (wr_dir)  dir   <= wdata;
      if (wr_ctrl) ie    <= wdata[CTRL_IE_BIT];
      if (access)  rdata <= rdata_d;
      ostrobe <= wr_data;
    end
  end
endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bpp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_sel,
  input  logic [2:0]    reg_sel,
  input  logic          bus_write,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          bus_req,
  output logic          bus_ack,
  output logic          irq,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  input  logic          cap_strobe,
  output logic          out_strobe
);
  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  logic          access;
  logic          rd_data;
  logic [DW-1:0] din;
  logic          flag;
  logic          ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  bpp_handshake u_hs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .sel    (dev_sel),
    .req    (bus_req),
    .ack    (bus_ack),
    .access (access)
  );

  bpp_capture #(.W(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .strobe (cap_strobe),
    .pins   (pin_in),
    .clr    (rd_data),
    .din    (din),
    .flag   (flag)
  );

  bpp_regs #(.W(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .access  (access),
    .write   (bus_write),
    .rs      (reg_sel),
    .wdata   (bus_wdata),
    .din     (din),
    .flag    (flag),
    .dout    (pin_out),
    .dir     (pin_oe),
    .ie      (ie),
    .rdata   (bus_rdata),
    .ostrobe (out_strobe),
    .rd_data (rd_data)
  );

  assign irq = flag & ie;
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_sel,
  input logic [2:0] reg_sel,
  input logic       bus_write,
  input logic       bus_req,
  input logic       bus_ack,
  input logic       irq,
  input logic [7:0] pin_out,
  input logic [7:0] pin_oe,
  input logic       cap_strobe,
  input logic       out_strobe
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == 8'h00 && pin_out == 8'h00 && !bus_ack && !irq && !out_strobe));

  assert_ack_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(dev_sel && bus_req));

  assert_dir_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(dev_sel && bus_req && !bus_ack && bus_write && reg_sel == 3'd1));

  assert_out_only_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(dev_sel && bus_req && !bus_ack && bus_write && reg_sel == 3'd0));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cap_strobe) || $past(dev_sel && bus_req && bus_write && reg_sel == 3'd2)));
endmodule

bind bidir_port bpp_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_sel    (dev_sel),
  .reg_sel    (reg_sel),
  .bus_write  (bus_write),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .irq        (irq),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .cap_strobe (cap_strobe),
  .out_strobe (out_strobe)
);

// File: tb/sim_bidir_port.sv
`timescale 1ns/1ps
module sim_bidir_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_sel, bus_write, bus_req, cap_strobe;
  logic [2:0] reg_sel;
  logic [7:0] bus_wdata, pin_in;
  logic [7:0] bus_rdata, pin_out, pin_oe;
  logic       bus_ack, irq, out_strobe;

  int checks = 0;
  int failures = 0;
  logic       ack_seen, strobe_seen;
  logic [7:0] rd;

  always #4 clk = ~clk;

  bidir_port u0 (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .reg_sel(reg_sel),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_ack(bus_ack), .irq(irq), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .cap_strobe(cap_strobe),
    .out_strobe(out_strobe)
  );

  // {write, code, wdata, pins, expected rdata}
  localparam logic [27:0] VEC [0:10] = '{
    {1'b1, 3'd1, 8'hF0, 8'h00, 8'h00},  // R3 dir = F0
    {1'b1, 3'd0, 8'hA5, 8'h3C, 8'h00},  // R4 dout = A5
    {1'b0, 3'd0, 8'h00, 8'h3C, 8'hAC},  // R5 mixed read
    {1'b0, 3'd1, 8'h00, 8'h3C, 8'hF0},  // R3 dir readback
    {1'b0, 3'd2, 8'h00, 8'h3C, 8'h00},  // R8 status idle
    {1'b0, 3'd5, 8'h00, 8'h3C, 8'h00},  // R9 unused read
    {1'b1, 3'd1, 8'h0F, 8'h81, 8'h00},  // R3 dir = 0F
    {1'b0, 3'd0, 8'h00, 8'h81, 8'h85},  // R5 mixed read
    {1'b1, 3'd6, 8'hFF, 8'h81, 8'h00},  // R9 unused write
    {1'b0, 3'd1, 8'h00, 8'h81, 8'h0F},  // R9 dir untouched
    {1'b0, 3'd7, 8'h00, 8'h81, 8'h00}   // R9 unused read
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [2:0] rs, input logic [7:0] wd,
                        output logic [7:0] rdv);
    @(negedge clk);
    dev_sel = 1'b1; bus_req = 1'b1; bus_write = we; reg_sel = rs; bus_wdata = wd;
    @(negedge clk);
    rdv = bus_rdata; ack_seen = bus_ack; strobe_seen = out_strobe;
    dev_sel = 1'b0; bus_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_cap(input logic [7:0] p);
    @(negedge clk); pin_in = p; cap_strobe = 1'b1;
    @(negedge clk); cap_strobe = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 ack/irq/strobe", {5'b0, bus_ack, irq, out_strobe}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    dev_sel = 0; bus_write = 0; bus_req = 0; cap_strobe = 0;
    reg_sel = 0; bus_wdata = 0; pin_in = 0;
    do_reset();

    for (int k = 0; k < 11; k++) begin
      pin_in = VEC[k][15:8];
      repeat (2) @(negedge clk);
      bus_op(VEC[k][27], VEC[k][26:24], VEC[k][23:16], rd);
      chk("R2 ack on vector", {7'b0, ack_seen}, 8'h01);
      chk("R5/R9 vector rdata", rd, VEC[k][7:0]);
    end
    chk("R3 pin_oe", pin_oe, 8'h0F);
    chk("R4 pin_out", pin_out, 8'hA5);

    // R4 strobe pulse, R2 held request performs one access
    bus_op(1'b1, 3'd0, 8'h3C, rd);
    chk("R4 strobe after write", {7'b0, strobe_seen}, 8'h01);
    chk("R4 strobe one cycle", {7'b0, out_strobe}, 8'h00);
    begin
      int pulses = 0;
      int acks = 0;
      @(negedge clk);
      dev_sel = 1; bus_req = 1; bus_write = 1; reg_sel = 3'd0; bus_wdata = 8'h3C;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (out_strobe) pulses++;
        if (bus_ack) acks++;
      end
      dev_sel = 0; bus_req = 0;
      @(negedge clk);
      chk("R2 single access strobes", 8'(pulses), 8'd1);
      chk("R2 ack held", 8'(acks), 8'd4);
      chk("R2 ack drops", {7'b0, bus_ack}, 8'h00);
    end

    // R6 capture freezes input bits; dir=0F dout=3C
    pulse_cap(8'h5A);
    pin_in = 8'h11;
    repeat (3) @(negedge clk);
    bus_op(1'b0, 3'd2, 8'h00, rd);
    chk("R6 flag set", rd, 8'h01);
    bus_op(1'b0, 3'd0, 8'h00, rd);
    chk("R6 frozen capture", rd, 8'h5C);
    bus_op(1'b0, 3'd2, 8'h00, rd);
    chk("R7 flag cleared by read", rd, 8'h00);
    bus_op(1'b0, 3'd0, 8'h00, rd);
    chk("R5 live tracking", rd, 8'h1C);

    // R8 interrupt
    bus_op(1'b1, 3'd2, 8'h02, rd);
    chk("R8 irq low no flag", {7'b0, irq}, 8'h00);
    pulse_cap(8'h33);
    @(negedge clk);
    chk("R8 irq high", {7'b0, irq}, 8'h01);
    bus_op(1'b0, 3'd2, 8'h00, rd);
    chk("R8 status view", rd, 8'h03);
    bus_op(1'b0, 3'd0, 8'h00, rd);
    chk("R6 captured read", rd, 8'h3C);
    chk("R8 irq cleared", {7'b0, irq}, 8'h00);

    // R7 capture edge in the same cycle as a clearing read
    repeat (2) @(negedge clk);
    @(negedge clk);
    pin_in = 8'h77; cap_strobe = 1;
    dev_sel = 1; bus_req = 1; bus_write = 0; reg_sel = 3'd0;
    @(negedge clk);
    chk("R7 read during capture", bus_rdata, 8'h3C);
    chk("R7 flag survives", {7'b0, irq}, 8'h01);
    dev_sel = 0; bus_req = 0; cap_strobe = 0;
    @(negedge clk);
    bus_op(1'b0, 3'd2, 8'h00, rd);
    chk("R7 status after collision", rd, 8'h03);

    // R10 unselected request
    @(negedge clk);
    dev_sel = 0; bus_req = 1; bus_write = 1; reg_sel = 3'd1; bus_wdata = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R10 no ack", {7'b0, bus_ack}, 8'h00);
    chk("R10 dir unchanged", pin_oe, 8'h0F);
    bus_req = 0;
    bus_op(1'b0, 3'd1, 8'h00, rd);
    chk("R10 dir readback", rd, 8'h0F);

    // R1 reset mid-run
    do_reset();
    bus_op(1'b0, 3'd1, 8'h00, rd);
    chk("R1 dir after reset", rd, 8'h00);
    bus_op(1'b0, 3'd2, 8'h00, rd);
    chk("R1 status after reset", rd, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule